// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash command at a time over a single-lane SPI bus (one MOSI line, one MISO line). Software fills a 32-bit command descriptor, an address register and two write-data registers through a small register port. It then writes the value 1 to a start register. The block asserts chip select and shifts the frame out in a fixed order: opcode, then address, then dummy clocks, then data. During a read command it packs the bytes from MISO into two read-data registers, which software fetches once the busy flag in the status register has cleared.

Every field of a command can be chosen freely. Opcode-only commands such as write-enable are possible, and so are 3-byte or 4-byte address commands, status or ID reads of up to eight bytes, and writes of up to eight bytes. The SPI clock is the system clock divided by the even parameter `SCK_DIV`. The bus runs in mode 0: the clock idles low, the design changes MOSI on the falling edge, and both sides sample on the rising edge. A control bit enables the SPI output drivers. While this bit is clear, no command runs.

The register port has no back-pressure. A request is a read or write strobe that the host holds high until `reg_ready` rises. `reg_ready` rises in the cycle after the strobe is first seen and stays high for one cycle. The host drops the strobe in that cycle. `reg_rdata` is valid while `reg_ready` is high.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: The descriptor register (offset 0x08) holds the opcode in bits 7:0, the address byte count in bits 10:8, the direction in bit 11 (1 = read, 0 = write), the data byte count in bits 15:12 and the dummy clock count in bits 20:16. Bits 31:21 are stored and read back but have no effect.
- R2: A command starts only when the value 32'h1 is written to the start register (offset 0x0C) while the block is idle and enabled. A start write with any other value, a start write while busy, and writes to any other register do not start a command. The descriptor, address and write-data values are captured when the command starts.
- R3: Each frame begins with the 8 opcode bits, sent MSB first. SCK is low whenever chip select is high. MOSI changes only while SCK is low.
- R4: The address phase sends the low N bytes of the address register (offset 0x10), where N is the address byte count limited to 4. The most significant of those bytes goes first, and each byte is sent MSB first. When N is 0, the address phase is omitted.
- R5: The dummy phase lasts exactly the programmed number of SCK cycles, and MOSI is low during it.
- R6: For a write, the data phase sends M bytes, where M is the data byte count limited to 8. Byte k is bits 8k+7:8k of the 64-bit value {WD1 (0x18), WD0 (0x14)}, and each byte is sent MSB first.
- R7: For a read, MOSI is low during the data phase. Byte k received (MSB first) is stored in bits 8k+7:8k of {RD1 (0x20), RD0 (0x1C)}. Both registers are cleared when a read command starts, so bytes that are not received read as zero.
- R8: Chip select is low from before the first SCK rise until after the last SCK fall. It is high whenever the block is idle, and between two commands it stays high for at least one SCK period.
- R9: One SCK period lasts SCK_DIV system clocks, with SCK high for SCK_DIV/2 of them.
- R10: Control bit 0 (offset 0x00) enables the outputs and drives `spi_oe`. While it is 0, chip select is high, SCK and MOSI are low, start writes are ignored, and a command in progress is abandoned.
- R11: Status bit 0 (offset 0x04) and the `busy` port are 1 from the cycle after an accepted start until the gap after the frame has ended.
- R12: `reg_ready` is high exactly one cycle after a request is accepted, and `reg_rdata` holds the addressed register during that cycle. The start register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_ready |
| reg_ready | output | 1 | Request completion pulse |
| busy | output | 1 | Command in progress |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_oe | output | 1 | Output enable for the SPI pad drivers |

## Verification
The assertions check the pin protocol on every cycle. SCK must stay low while chip select is high. MOSI must hold steady while SCK is high. Chip select must be high whenever the block is idle. The SCK high time must match the divider. A cleared enable must return the block to idle in the next cycle. The bench scenarios cover the rest: a flash model sweeps every address count (including the limited values), data counts from zero through the limit and beyond, both directions, and two dummy lengths. For each command it compares each phase of the captured MOSI stream bit by bit, and checks the read-data packing and clearing, the rules under which a start write is ignored, and the abandoning of a command when the enable bit is cleared.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL   = 6'h00;
  localparam logic [REG_AW-1:0] OFS_STATUS = 6'h04;
  localparam logic [REG_AW-1:0] OFS_DESC   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_START  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_ADDR   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_WD0    = 6'h14;
  localparam logic [REG_AW-1:0] OFS_WD1    = 6'h18;
  localparam logic [REG_AW-1:0] OFS_RD0    = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_RD1    = 6'h20;

  localparam logic [2:0] MAX_ABYTES = 3'd4;
  localparam logic [3:0] MAX_DBYTES = 4'd8;

  // Command descriptor, packed MSB first
  typedef struct packed {
    logic [10:0] rsvd;
    logic [4:0]  dummy;
    logic [3:0]  dcnt;
    logic        rd;
    logic [2:0]  acnt;
    logic [7:0]  op;
  } cmd_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } eng_state_t;

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_ready,
  input  logic              busy,
  input  logic [63:0]       rx_data,
  output logic              en,
  output logic              start,
  output logic [7:0]        d_op,
  output logic [2:0]        d_acnt,
  output logic              d_rd,
  output logic [3:0]        d_dcnt,
  output logic [4:0]        d_dummy,
  output logic [31:0]       addr_q,
  output logic [63:0]       wdata_q
);

  cmd_desc_t   desc_q;
  logic        ready_q;
  logic        take;
  logic [31:0] rd_mux;

  assign take  = (reg_rd | reg_wr) & ~ready_q;
  assign start = take & reg_wr & (reg_addr == OFS_START) & (reg_wdata == 32'd1);

  assign d_op    = desc_q.op;
  assign d_acnt  = desc_q.acnt;
  assign d_rd    = desc_q.rd;
  assign d_dcnt  = desc_q.dcnt;
  assign d_dummy = desc_q.dummy;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CTRL:   rd_mux = {31'd0, en};
      OFS_STATUS: rd_mux = {31'd0, busy};
      OFS_DESC:   rd_mux = desc_q;
      OFS_ADDR:   rd_mux = addr_q;
      OFS_WD0:    rd_mux = wdata_q[31:0];
      OFS_WD1:    rd_mux = wdata_q[63:32];
      OFS_RD0:    rd_mux = rx_data[31:0];
      OFS_RD1:    rd_mux = rx_data[63:32];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      reg_rdata <= '0;
      en        <= 1'b0;
      desc_q    <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      ready_q <= take;
      if (take && reg_rd) reg_rdata <= rd_mux;
      if (take && reg_wr) begin
        case (reg_addr)
          OFS_CTRL: en             <= reg_wdata[0];
          OFS_DESC: desc_q         <= reg_wdata;
          OFS_ADDR: addr_q         <= reg_wdata;
          OFS_WD0:  wdata_q[31:0]  <= reg_wdata;
          OFS_WD1:  wdata_q[63:32] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign reg_ready = ready_q;

endmodule

// File: rtl/spi_seq_bitsel.sv
module spi_seq_bitsel #(
  parameter int unsigned IW = 8
) (
  input  logic [IW-1:0] idx,
  input  logic [7:0]    op,
  input  logic [2:0]    acnt,
  input  logic [4:0]    dummy,
  input  logic [3:0]    dcnt,
  input  logic          rd,
  input  logic [31:0]   addr,
  input  logic [63:0]   wdata,
  output logic          bit_o,
  output logic          in_data,
  output logic [5:0]    dpos,
  output logic [IW-1:0] last_idx
);

  logic [IW-1:0] a_bits;
  logic [IW-1:0] a_end;
  logic [IW-1:0] d_end;
  logic [4:0]    apos;
  logic [5:0]    jd;

  assign a_bits   = IW'(acnt) << 3;
  assign a_end    = IW'(8) + a_bits;
  assign d_end    = a_end + IW'(dummy);
  assign last_idx = d_end + (IW'(dcnt) << 3) - IW'(1);

  // address bit: highest sent byte first, MSB first inside it
  assign apos = 5'(a_bits - IW'(1) - (idx - IW'(8)));
  // data bit: byte index in upper bits, bit reversed in lower bits
  assign jd   = 6'(idx - d_end);
  assign dpos = {jd[5:3], ~jd[2:0]};

  always_comb begin
    bit_o   = 1'b0;
    in_data = 1'b0;
    if (idx < IW'(8)) begin
      bit_o = op[~idx[2:0]];
    end else if (idx < a_end) begin
      bit_o = addr[apos];
    end else if (idx < d_end) begin
      bit_o = 1'b0;
    end else begin
      in_data = 1'b1;
      bit_o   = rd ? 1'b0 : wdata[dpos];
    end
  end

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int unsigned DIV = 4,
  parameter int unsigned IW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic [7:0]    d_op,
  input  logic [2:0]    d_acnt,
  input  logic          d_rd,
  input  logic [3:0]    d_dcnt,
  input  logic [4:0]    d_dummy,
  input  logic [31:0]   addr_in,
  input  logic [63:0]   wdata_in,
  input  logic          miso,
  input  logic          sel_in_data,
  input  logic [5:0]    sel_dpos,
  input  logic [IW-1:0] sel_last,
  output logic [IW-1:0] idx,
  output logic [7:0]    l_op,
  output logic [2:0]    l_acnt,
  output logic          l_rd,
  output logic [3:0]    l_dcnt,
  output logic [4:0]    l_dummy,
  output logic [31:0]   l_addr,
  output logic [63:0]   l_wdata,
  output logic          busy,
  output logic          shifting,
  output logic          sck,
  output logic          cs_n,
  output logic [63:0]   rx_data
);

  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV) + 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0] GAP_M1  = CW'(DIV - 1);

  eng_state_t    st;
  logic [CW-1:0] cnt;

  assign busy     = (st != ST_IDLE);
  assign shifting = (st == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      l_op    <= '0;
      l_acnt  <= '0;
      l_rd    <= 1'b0;
      l_dcnt  <= '0;
      l_dummy <= '0;
      l_addr  <= '0;
      l_wdata <= '0;
      rx_data <= '0;
    end else if (!en) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sck  <= 1'b0;
      cs_n <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            l_op    <= d_op;
            l_acnt  <= (d_acnt > MAX_ABYTES) ? MAX_ABYTES : d_acnt;
            l_rd    <= d_rd;
            l_dcnt  <= (d_dcnt > MAX_DBYTES) ? MAX_DBYTES : d_dcnt;
            l_dummy <= d_dummy;
            l_addr  <= addr_in;
            l_wdata <= wdata_in;
            st      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          cs_n <= 1'b0;
          sck  <= 1'b0;
          idx  <= '0;
          cnt  <= '0;
          if (l_rd) rx_data <= '0;
          st   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (cnt == HALF_M1) begin
            cnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
              if (l_rd && sel_in_data) rx_data[sel_dpos] <= miso;
            end else begin
              sck <= 1'b0;
              if (idx == sel_last) st <= ST_TAIL;
              else                 idx <= idx + IW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_TAIL: begin
          if (cnt == HALF_M1) begin
            cnt  <= '0;
            cs_n <= 1'b1;
            st   <= ST_GAP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_GAP: begin
          if (cnt == GAP_M1) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_flash_cmd_seq.sv
module spi_flash_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned SCK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_ready,
  output logic        busy,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_oe
);

  // widest frame: 8 + 32 + 31 + 64 bits
  localparam int unsigned IW = 8;

  logic          en, start;
  logic [7:0]    d_op, l_op;
  logic [2:0]    d_acnt, l_acnt;
  logic          d_rd, l_rd;
  logic [3:0]    d_dcnt, l_dcnt;
  logic [4:0]    d_dummy, l_dummy;
  logic [31:0]   addr_q, l_addr;
  logic [63:0]   wdata_q, l_wdata, rx_data;
  logic [IW-1:0] idx, sel_last;
  logic          sel_bit, sel_in_data;
  logic [5:0]    sel_dpos;
  logic          shifting, sck_q, cs_n_q;

  spi_seq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_ready (reg_ready),
    .busy      (busy),
    .rx_data   (rx_data),
    .en        (en),
    .start     (start),
    .d_op      (d_op),
    .d_acnt    (d_acnt),
    .d_rd      (d_rd),
    .d_dcnt    (d_dcnt),
    .d_dummy   (d_dummy),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q)
  );

  spi_seq_engine #(.DIV(SCK_DIV), .IW(IW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .start       (start),
    .d_op        (d_op),
    .d_acnt      (d_acnt),
    .d_rd        (d_rd),
    .d_dcnt      (d_dcnt),
    .d_dummy     (d_dummy),
    .addr_in     (addr_q),
    .wdata_in    (wdata_q),
    .miso        (spi_miso),
    .sel_in_data (sel_in_data),
    .sel_dpos    (sel_dpos),
    .sel_last    (sel_last),
    .idx         (idx),
    .l_op        (l_op),
    .l_acnt      (l_acnt),
    .l_rd        (l_rd),
    .l_dcnt      (l_dcnt),
    .l_dummy     (l_dummy),
    .l_addr      (l_addr),
    .l_wdata     (l_wdata),
    .busy        (busy),
    .shifting    (shifting),
    .sck         (sck_q),
    .cs_n        (cs_n_q),
    .rx_data     (rx_data)
  );

  spi_seq_bitsel #(.IW(IW)) u_sel (
    .idx      (idx),
    .op       (l_op),
    .acnt     (l_acnt),
    .dummy    (l_dummy),
    .dcnt     (l_dcnt),
    .rd       (l_rd),
    .addr     (l_addr),
    .wdata    (l_wdata),
    .bit_o    (sel_bit),
    .in_data  (sel_in_data),
    .dpos     (sel_dpos),
    .last_idx (sel_last)
  );

  assign spi_oe   = en;
  assign spi_cs_n = cs_n_q | ~en;
  assign spi_sck  = sck_q & en;
  assign spi_mosi = sel_bit & shifting & en;

endmodule

// File: rtl/spi_flash_cmd_seq_chk.sv
module spi_flash_cmd_seq_chk #(
  parameter int unsigned DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic spi_oe,
  input logic busy
);

  localparam int unsigned HALF = DIV / 2;

  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (spi_sck) hi_cnt <= hi_cnt + 8'd1;
    else              hi_cnt <= '0;
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R3

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R3

  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n); // R8

  AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_sck) && spi_oe) |-> (hi_cnt == 8'(HALF))); // R9

  AST_OE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_oe |=> !busy); // R10

endmodule

bind spi_flash_cmd_seq spi_flash_cmd_seq_chk #(.DIV(SCK_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .spi_oe   (spi_oe),
  .busy     (busy)
);

// File: tb/test_spi_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_spi_flash_cmd_seq;

  localparam time TCLK = 8ns;
  localparam time TSCK = 32ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_rd, reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_ready, busy;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso, spi_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // flash model state
  int   nbits = 0;
  int   ncs   = 0;
  int   per_err = 0;
  int   gap_err = 0;
  bit   first_edge = 1'b1;
  bit   seen_cs_rise = 1'b0;
  time  last_rise, cs_rise_t;
  logic cap [0:255];

  always #(TCLK/2) clk = ~clk;

  spi_flash_cmd_seq i_spi_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .busy(busy), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_oe(spi_oe)
  );

  function automatic logic mbit(int k);
    int v = k * 11 + 5;
    return v[2] ^ v[5];
  endfunction

  initial forever begin
    @(negedge spi_cs_n);
    if (seen_cs_rise && ($time - cs_rise_t) < TSCK) gap_err++;
    nbits = 0;
    ncs++;
    first_edge = 1'b1;
    spi_miso = mbit(0);
  end

  initial forever begin
    @(posedge spi_cs_n);
    cs_rise_t = $time;
    seen_cs_rise = 1'b1;
  end

  initial forever begin
    @(posedge spi_sck);
    if (!first_edge && ($time - last_rise) != TSCK) per_err++;
    first_edge = 1'b0;
    last_rise = $time;
    if (nbits < 256) cap[nbits] = spi_mosi;
    nbits++;
  end

  initial forever begin
    @(negedge spi_sck);
    spi_miso = mbit(nbits);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; rdy = reg_ready;
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    logic r;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(6'h04, s, r);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic run_cmd(input int ab, input int db, input int dm, input bit dir,
                         input logic [7:0] op, input logic [31:0] addr,
                         input logic [63:0] wd);
    int abc, dbc, total, d_end, k;
    int e_op, e_ad, e_dm, e_dt;
    logic e;
    logic [31:0] r0, r1;
    logic rdy;
    logic [63:0] rexp;
    abc = (ab > 4) ? 4 : ab;
    dbc = (db > 8) ? 8 : db;
    d_end = 8 + 8 * abc + dm;
    total = d_end + 8 * dbc;
    bus_wr(6'h10, addr);
    bus_wr(6'h14, wd[31:0]);
    bus_wr(6'h18, wd[63:32]);
    bus_wr(6'h08, {11'd0, 5'(dm), 4'(db), dir, 3'(ab), op});
    bus_wr(6'h0C, 32'd1);
    wait_idle();
    chk(nbits == total, "R3 frame bit count", 64'(nbits), 64'(total));
    e_op = 0; e_ad = 0; e_dm = 0; e_dt = 0;
    for (int i = 0; i < total; i++) begin
      if (i < 8) begin
        e = op[7 - i];
        if (cap[i] !== e) e_op++;
      end else if (i < 8 + 8 * abc) begin
        k = i - 8;
        e = addr[8 * abc - 1 - k];
        if (cap[i] !== e) e_ad++;
      end else if (i < d_end) begin
        if (cap[i] !== 1'b0) e_dm++;
      end else begin
        k = i - d_end;
        e = dir ? 1'b0 : wd[8 * (k / 8) + 7 - (k % 8)];
        if (cap[i] !== e) e_dt++;
      end
    end
    chk(e_op == 0, "R3 opcode bits", 64'(e_op), 0);
    chk(e_ad == 0, "R4 address bits", 64'(e_ad), 0);
    chk(e_dm == 0, "R5 dummy bits low", 64'(e_dm), 0);
    chk(e_dt == 0, dir ? "R7 mosi low in read data" : "R6 write data bits", 64'(e_dt), 0);
    if (dir) begin
      rexp = '0;
      for (int b = 0; b < dbc; b++)
        for (int i = 0; i < 8; i++)
          rexp[8 * b + 7 - i] = mbit(d_end + 8 * b + i);
      bus_rd(6'h1C, r0, rdy);
      bus_rd(6'h20, r1, rdy);
      chk({r1, r0} == rexp, "R7 read data packing", {r1, r0}, rexp);
    end
  endtask

  initial begin
    logic [31:0] v;
    logic rdy;
    int n0;
    rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    spi_miso = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_oe == 1'b0, "R8 reset pins",
        {spi_cs_n, spi_sck, spi_oe}, 3'b100);
    bus_rd(6'h04, v, rdy);
    chk(rdy == 1'b1, "R12 ready after request", 64'(rdy), 1);
    chk(v == 0, "R11 status idle after reset", 64'(v), 0);
    bus_rd(6'h1C, v, rdy);
    chk(v == 0, "R7 read data reset", 64'(v), 0);

    // descriptor readback including reserved bits
    bus_wr(6'h08, 32'hFFE4_89F5);
    bus_rd(6'h08, v, rdy);
    chk(v == 32'hFFE4_89F5, "R1 descriptor readback", 64'(v), 64'h0FFE489F5);
    bus_rd(6'h0C, v, rdy);
    chk(v == 0, "R12 start reads zero", 64'(v), 0);

    // start while disabled
    n0 = ncs;
    bus_wr(6'h08, 32'h0000_0006);
    bus_wr(6'h0C, 32'd1);
    repeat (20) @(negedge clk);
    chk(ncs == n0 && spi_cs_n && !busy && !spi_oe, "R10 start ignored when disabled",
        64'(ncs - n0), 0);

    // enable, start with wrong value
    bus_wr(6'h00, 32'd1);
    bus_rd(6'h00, v, rdy);
    chk(v == 1 && spi_oe, "R10 enable bit", 64'(v), 1);
    bus_wr(6'h0C, 32'd2);
    repeat (20) @(negedge clk);
    chk(ncs == n0 && !busy, "R2 start value other than 1 ignored", 64'(ncs - n0), 0);

    // sweep: address counts 0..5, data counts 0..9, both directions
    for (int ab = 0; ab <= 5; ab++)
      for (int db = 0; db <= 9; db++)
        for (int dir = 0; dir < 2; dir++)
          run_cmd(ab, db, ((ab + db) % 2) ? 5 : 0, dir[0],
                  8'(8'h03 + ab * 16 + db), 32'hA1B2_C3D4 ^ (ab * 32'h0101_0101),
                  64'h1122_3344_5566_7788 ^ (64'(db) * 64'h0F0F_0000_00F0_F0F0));

    // start while busy is ignored; busy visible in status
    n0 = ncs;
    bus_wr(6'h08, {11'd0, 5'd2, 4'd8, 1'b1, 3'd3, 8'h0B});
    bus_wr(6'h0C, 32'd1);
    bus_wr(6'h08, 32'h0000_0006);
    bus_wr(6'h0C, 32'd1);
    bus_rd(6'h04, v, rdy);
    chk(v[0] == 1'b1 && busy, "R11 busy during command", 64'(v), 1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(ncs - n0 == 1, "R2 start while busy ignored", 64'(ncs - n0), 1);
    chk(nbits == 98, "R2 descriptor captured at start", 64'(nbits), 98);

    // abort by clearing enable
    bus_wr(6'h08, {11'd0, 5'd0, 4'd8, 1'b0, 3'd4, 8'hD8});
    bus_wr(6'h0C, 32'd1);
    repeat (40) @(negedge clk);
    bus_wr(6'h00, 32'd0);
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && !spi_mosi && !spi_oe, "R10 outputs off after abort",
        {spi_cs_n, spi_sck, spi_mosi, spi_oe}, 4'b1000);
    bus_rd(6'h04, v, rdy);
    chk(v == 0, "R10 command abandoned", 64'(v), 0);

    chk(per_err == 0, "R9 sck period", 64'(per_err), 0);
    chk(gap_err == 0, "R8 chip select gap", 64'(gap_err), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule